// File: doc/BRIEF.md
# Runtime-Configurable Serial Frame Transmitter

This block turns one parallel character into an asynchronous serial frame on a single output line. A frame has a low start bit, a data field of 5 to 9 bits sent least significant bit first, an optional parity bit and a high stop field. The data length, the parity mode and the stop length are chosen per character through configuration inputs, so one instance can serve links with different framing without being rebuilt.

A client presents the character and its configuration and pulses `start` for one cycle while `busy` is low. The block captures everything on that edge, raises `busy` and drives the frame. `busy` drops once the whole stop field has elapsed. The line length of one bit period is the clock frequency divided by the baud rate, both set by parameters. The stop field may last one, one and a half or two bit periods. The half period is timed as half the bit period, rounded down.

Top module: `uart_frame_tx`

## Requirements
- R1: Out of reset, and whenever `busy` is low, `txd` is 1 and `busy` is 0. An asynchronous reset during a frame returns the line to 1 at once.
- R2: A `start` pulse seen at a rising edge while `busy` is low is accepted. From that edge, `busy` is 1 and `txd` is 0 for exactly one bit period (the start bit).
- R3: The data field follows the start bit, least significant bit first. Its length is `cfg_bits`, and values below 5 act as 5 while values above 9 act as 9.
- R4: With `cfg_parity` = 1 (odd), the parity bit after the data is 1 when the sent data bits hold an even number of ones, and 0 otherwise.
- R5: With `cfg_parity` = 2 (even), the parity bit is 0 when the sent data bits hold an even number of ones, and 1 otherwise.
- R6: With `cfg_parity` = 3 the parity bit is always 1, and with 4 it is always 0. With 0, 5, 6 or 7 no parity bit is sent, and the stop field follows the last data bit.
- R7: The stop field drives `txd` high. `cfg_stop` = 0 gives one bit period, 1 gives one bit period plus half a bit period, and 2 or 3 gives two bit periods. `busy` falls on the edge where the stop field ends.
- R8: Each start, data and parity bit lasts exactly CLK_HZ/BAUD clock cycles.
- R9: Data and configuration are captured on the accepting edge. Changes to them during a frame do not alter that frame.
- R10: A `start` pulse while `busy` is high is ignored. It neither restarts nor extends the frame, and no frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_data | input | MAX_BITS | Character to send, bit 0 first |
| cfg_bits | input | 4 | Data length in bits (5 to 9, clamped) |
| cfg_parity | input | 3 | Parity mode: 0 none, 1 odd, 2 even, 3 always 1, 4 always 0, other values none |
| cfg_stop | input | 2 | Stop length: 0 one, 1 one and a half, 2 or 3 two bit periods |
| start | input | 1 | One-cycle request to send |
| busy | output | 1 | High from the cycle after an accepted request to the end of the stop field |
| txd | output | 1 | Serial line, high when idle |

## Verification
The assertions assume that `start`, `tx_data` and the configuration inputs are synchronous to `clk`. They also assume the parameters give a bit period of at least two cycles, so that a half period is never empty. The bench changes every input one nanosecond after a rising edge, or on a falling edge, and never near a sampling edge. It checks each frame against a waveform built from the rules, cycle by cycle. In alternate frames it deliberately scrambles the data and configuration and fires extra `start` pulses after the frame has been accepted.

// File: rtl/uft_pkg.sv
package uft_pkg;

   typedef enum logic [2:0] {
      PAR_NONE  = 3'd0,
      PAR_ODD   = 3'd1,
      PAR_EVEN  = 3'd2,
      PAR_MARK  = 3'd3,
      PAR_SPACE = 3'd4
   } par_mode_e;

   typedef enum logic [1:0] {
      STOP_ONE     = 2'd0,
      STOP_ONEHALF = 2'd1,
      STOP_TWO     = 2'd2
   } stop_len_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_PAR   = 3'd3,
      ST_STOP1 = 3'd4,
      ST_STOP2 = 3'd5
   } tx_state_e;

   localparam int LEN_W = 4;

   function automatic par_mode_e decode_parity(input logic [2:0] code);
      case (code)
         3'd1:    return PAR_ODD;
         3'd2:    return PAR_EVEN;
         3'd3:    return PAR_MARK;
         3'd4:    return PAR_SPACE;
         default: return PAR_NONE;
      endcase
   endfunction

   function automatic stop_len_e decode_stop(input logic [1:0] code);
      case (code)
         2'd0:    return STOP_ONE;
         2'd1:    return STOP_ONEHALF;
         default: return STOP_TWO;
      endcase
   endfunction

endpackage

// File: rtl/uft_bit_timer.sv
module uft_bit_timer #(
   parameter int FULL_CYC = 16,
   parameter int HALF_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic half,
   output logic done
);
   localparam int CNT_W = (FULL_CYC > 2) ? $clog2(FULL_CYC) : 1;
   localparam logic [CNT_W-1:0] FULL_LD = CNT_W'(FULL_CYC - 1);
   localparam logic [CNT_W-1:0] HALF_LD = CNT_W'(HALF_CYC - 1);

   generate
      if (FULL_CYC < 2) begin : g_bad_full
         $error("uft_bit_timer: FULL_CYC must be at least 2");
      end
      if (HALF_CYC < 1 || HALF_CYC > FULL_CYC) begin : g_bad_half
         $error("uft_bit_timer: HALF_CYC out of range");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= half ? HALF_LD : FULL_LD;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign done = (cnt == '0);

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL_LD); // R8

   AST_HALF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (load && half) |=> (cnt == HALF_LD)); // R7

endmodule

// File: rtl/uft_parity.sv
module uft_parity
   import uft_pkg::*;
#(
   parameter int MAX_BITS = 9
) (
   input  logic [MAX_BITS-1:0] data,
   input  logic [LEN_W-1:0]    len,
   input  par_mode_e           mode,
   output logic                bit_out
);
   logic [MAX_BITS-1:0] masked;
   logic                ones_odd;

   generate
      for (genvar i = 0; i < MAX_BITS; i++) begin : g_mask
         assign masked[i] = data[i] & (len > LEN_W'(i));
      end
   endgenerate

   assign ones_odd = ^masked;

   always_comb begin
      case (mode)
         PAR_ODD:   bit_out = ~ones_odd;
         PAR_EVEN:  bit_out = ones_odd;
         PAR_MARK:  bit_out = 1'b1;
         default:   bit_out = 1'b0;
      endcase
   end

endmodule

// File: rtl/uft_shifter.sv
module uft_shifter #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   input  logic         shift,
   output logic         lsb
);
   logic [W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr <= '0;
      end else if (load) begin
         sr <= din;
      end else if (shift) begin
         sr <= {1'b0, sr[W-1:1]};
      end
   end

   assign lsb = sr[0];

   AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && !load) |=> (lsb == $past(sr[1]))); // R3

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
   import uft_pkg::*;
#(
   parameter int CLK_HZ   = 50_000_000,
   parameter int BAUD     = 9600,
   parameter int MAX_BITS = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [MAX_BITS-1:0] tx_data,
   input  logic [3:0]          cfg_bits,
   input  logic [2:0]          cfg_parity,
   input  logic [1:0]          cfg_stop,
   input  logic                start,
   output logic                busy,
   output logic                txd
);
   localparam int BIT_CYC  = CLK_HZ / BAUD;
   localparam int HALF_CYC = BIT_CYC / 2;
   localparam int MIN_BITS = 5;

   generate
      if (BAUD < 1 || BIT_CYC < 2) begin : g_bad_rate
         $error("uart_frame_tx: CLK_HZ/BAUD must be at least 2");
      end
      if (MAX_BITS < MIN_BITS || MAX_BITS > 15) begin : g_bad_width
         $error("uart_frame_tx: MAX_BITS must be 5..15");
      end
   endgenerate

   function automatic logic [LEN_W-1:0] clamp_len(input logic [3:0] b);
      if (b < LEN_W'(MIN_BITS))      return LEN_W'(MIN_BITS);
      else if (b > LEN_W'(MAX_BITS)) return LEN_W'(MAX_BITS);
      else                           return b;
   endfunction

   tx_state_e           state;
   logic [MAX_BITS-1:0] data_q;
   logic [LEN_W-1:0]    len_q;
   logic [LEN_W-1:0]    left_q;
   par_mode_e           par_q;
   stop_len_e           stop_q;
   logic                txd_q;

   logic accept, seg_end, tmr_done, tmr_load, tmr_half, sr_shift, sr_lsb, par_bit;

   assign accept  = start && (state == ST_IDLE);
   assign seg_end = tmr_done && (state != ST_IDLE);

   always_comb begin
      tmr_load = 1'b0;
      tmr_half = 1'b0;
      sr_shift = 1'b0;
      if (accept) begin
         tmr_load = 1'b1;
      end else if (seg_end) begin
         case (state)
            ST_START: begin
               tmr_load = 1'b1;
               sr_shift = 1'b1;
            end
            ST_DATA: begin
               tmr_load = 1'b1;
               sr_shift = (left_q != '0);
            end
            ST_PAR: tmr_load = 1'b1;
            ST_STOP1: begin
               tmr_load = (stop_q != STOP_ONE);
               tmr_half = (stop_q == STOP_ONEHALF);
            end
            default: ;
         endcase
      end
   end

   uft_bit_timer #(
      .FULL_CYC (BIT_CYC),
      .HALF_CYC (HALF_CYC)
   ) timer_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tmr_load),
      .half  (tmr_half),
      .done  (tmr_done)
   );

   uft_shifter #(
      .W (MAX_BITS)
   ) shifter_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .din   (tx_data),
      .shift (sr_shift),
      .lsb   (sr_lsb)
   );

   uft_parity #(
      .MAX_BITS (MAX_BITS)
   ) parity_i (
      .data    (data_q),
      .len     (len_q),
      .mode    (par_q),
      .bit_out (par_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         data_q <= '0;
         len_q  <= LEN_W'(MIN_BITS);
         left_q <= '0;
         par_q  <= PAR_NONE;
         stop_q <= STOP_ONE;
         txd_q  <= 1'b1;
      end else if (accept) begin
         state  <= ST_START;
         data_q <= tx_data;
         len_q  <= clamp_len(cfg_bits);
         left_q <= clamp_len(cfg_bits) - 1'b1;
         par_q  <= decode_parity(cfg_parity);
         stop_q <= decode_stop(cfg_stop);
         txd_q  <= 1'b0;
      end else if (seg_end) begin
         case (state)
            ST_START: begin
               txd_q <= sr_lsb;
               state <= ST_DATA;
            end
            ST_DATA: begin
               if (left_q != '0) begin
                  txd_q  <= sr_lsb;
                  left_q <= left_q - 1'b1;
               end else if (par_q != PAR_NONE) begin
                  txd_q <= par_bit;
                  state <= ST_PAR;
               end else begin
                  txd_q <= 1'b1;
                  state <= ST_STOP1;
               end
            end
            ST_PAR: begin
               txd_q <= 1'b1;
               state <= ST_STOP1;
            end
            ST_STOP1: state <= (stop_q == STOP_ONE) ? ST_IDLE : ST_STOP2;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state != ST_IDLE);
   assign txd  = txd_q;

   AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd); // R1

   AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !txd)); // R2

   AST_START_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_START) |-> !txd); // R2

   AST_STOP_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STOP1 || state == ST_STOP2) |-> txd); // R7

   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && state != ST_START) |=> (state != ST_START)); // R10

   AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (len_q >= LEN_W'(MIN_BITS) && len_q <= LEN_W'(MAX_BITS))); // R3

endmodule

// File: tb/uart_frame_tx_tb_top.sv
`timescale 1ns/1ps
module uart_frame_tx_tb_top;
   localparam int CLK_HZ = 1600;
   localparam int BAUD   = 100;
   localparam int BIT    = CLK_HZ / BAUD;
   localparam int HALF   = BIT / 2;
   localparam int NVEC   = 8;

   // fields: {data[8:0], bits[3:0], parity[2:0], stop[1:0]}
   localparam logic [17:0] VEC [0:NVEC-1] = '{
      {9'h0D9, 4'd8,  3'd0, 2'd0},  // R3 R6 R7: 8 bits, no parity, 1 stop
      {9'h0A5, 4'd8,  3'd1, 2'd2},  // R4 R7: odd, 4 ones -> 1, 2 stop
      {9'h1C3, 4'd9,  3'd2, 2'd1},  // R5 R7: even, 5 ones -> 1, 1.5 stop
      {9'h015, 4'd5,  3'd3, 2'd0},  // R6: parity always 1
      {9'h07F, 4'd7,  3'd4, 2'd1},  // R6: parity always 0
      {9'h1FF, 4'd3,  3'd2, 2'd2},  // R3: length 3 acts as 5
      {9'h155, 4'd15, 3'd1, 2'd0},  // R3 R4: length 15 acts as 9
      {9'h02A, 4'd6,  3'd6, 2'd3}   // R6 R7: code 6 no parity, code 3 two stop
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] tx_data = '0;
   logic [3:0] cfg_bits = 4'd8;
   logic [2:0] cfg_parity = '0;
   logic [1:0] cfg_stop = '0;
   logic       start = 1'b0;
   logic       busy, txd;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   uart_frame_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .MAX_BITS(9)) dut_i (
      .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .cfg_bits(cfg_bits),
      .cfg_parity(cfg_parity), .cfg_stop(cfg_stop), .start(start),
      .busy(busy), .txd(txd));

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int eff_len(input int b);
      return (b < 5) ? 5 : ((b > 9) ? 9 : b);
   endfunction

   task automatic run_frame(input logic [8:0] d, input logic [3:0] b,
                            input logic [2:0] p, input logic [1:0] s,
                            input bit hammer);
      logic exp_bits [0:15];
      int   n, len, ones, pm, stop_c, total, bad_c, bad_a, bad_e, busy_bad;
      len  = eff_len(int'(b));
      pm   = (p > 3'd4) ? 0 : int'(p);
      ones = 0;
      exp_bits[0] = 1'b0;
      n = 1;
      for (int i = 0; i < len; i++) begin
         exp_bits[n] = d[i];
         ones += int'(d[i]);
         n++;
      end
      if (pm != 0) begin
         case (pm)
            1:       exp_bits[n] = (ones % 2 == 0);
            2:       exp_bits[n] = (ones % 2 == 1);
            3:       exp_bits[n] = 1'b1;
            default: exp_bits[n] = 1'b0;
         endcase
         n++;
      end
      stop_c = (s == 2'd0) ? BIT : ((s == 2'd1) ? BIT + HALF : 2 * BIT);
      total  = n * BIT + stop_c;
      bad_c = -1; bad_a = 0; bad_e = 0; busy_bad = -1;
      @(negedge clk);
      tx_data = d; cfg_bits = b; cfg_parity = p; cfg_stop = s; start = 1'b1;
      @(posedge clk);
      for (int c = 0; c <= total; c++) begin
         logic ew;
         #1;
         ew = (c < n * BIT) ? exp_bits[c / BIT] : 1'b1;
         if (c == 0)
            check(busy && !txd, "R2", "accept busy/txd", {busy, txd}, 2);
         if (bad_c < 0 && txd !== ew) begin
            bad_c = c; bad_a = int'(txd); bad_e = int'(ew);
         end
         if (busy_bad < 0 && busy !== (c < total)) busy_bad = c;
         if (c == 0) begin
            start = 1'b0;
            if (hammer) begin  // R9: scramble inputs after capture
               tx_data = ~d; cfg_bits = 4'd5; cfg_parity = 3'd3; cfg_stop = 2'd0;
            end
         end
         if (hammer && c == 2 * BIT)     start = 1'b1;  // R10
         if (hammer && c == 2 * BIT + 1) start = 1'b0;
         @(posedge clk);
      end
      if (bad_c >= 0)
         $display("FAIL R3/R4/R5/R6/R7/R8/R9 line at cycle %0d: actual=%0d expected=%0d",
                  bad_c, bad_a, bad_e);
      checks++;
      if (bad_c >= 0) errors++;
      check(busy_bad < 0, hammer ? "R10" : "R7", "busy window (first bad cycle)",
            busy_bad, -1);
   endtask

   initial begin
      int zeros;
      #9;
      check(txd === 1'b1 && busy === 1'b0, "R1", "reset txd/busy", {busy, txd}, 1);
      @(negedge clk); rst_n = 1'b1;
      zeros = 0;
      for (int i = 0; i < 20; i++) begin
         @(posedge clk); #1;
         if (txd !== 1'b1 || busy !== 1'b0) zeros++;
      end
      check(zeros == 0, "R1", "idle cycles off level", zeros, 0);

      for (int v = 0; v < NVEC; v++)
         run_frame(VEC[v][17:9], VEC[v][8:5], VEC[v][4:2], VEC[v][1:0], (v % 2) == 1);

      // back-to-back: strobe on first idle cycle after a frame
      run_frame(9'h000, 4'd5, 3'd1, 2'd0, 1'b0);  // R4: zero ones -> 1
      run_frame(9'h1FF, 4'd9, 3'd2, 2'd1, 1'b1);  // R5: nine ones -> 1

      // R1: reset in the middle of a frame
      @(negedge clk);
      tx_data = 9'h000; cfg_bits = 4'd8; cfg_parity = 3'd0; cfg_stop = 2'd0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (3 * BIT) @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(txd === 1'b1 && busy === 1'b0, "R1", "mid-frame reset", {busy, txd}, 1);
      @(negedge clk); rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      check(txd === 1'b1 && busy === 1'b0, "R1", "after reset release", {busy, txd}, 1);
      run_frame(9'h0C3, 4'd8, 3'd2, 2'd2, 1'b0);  // R2 R8: frame after reset

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule